// File: doc/BRIEF.md
# Reloadable 24-bit Transfer Byte Counter

This block counts bytes for a controller that can move data by DMA. Software writes a three-byte transfer count into holding registers. A command that carries the DMA flag copies that value into a working counter. A command that also asks for a transfer starts a run. The length of the run is the programmed count, with zero standing for 65536, limited by the number of bytes left in the current bus phase. Each byte-moved strobe takes one from the working counter. When the counter reaches zero, a one-cycle done pulse is raised and the terminal-count flag is set. Neighbouring logic uses that pulse to load the bus-service interrupt code and to clear the sequence step and the FIFO flags.

The working counter can be read at the same three byte addresses that software writes. The top byte reads back a fixed identifier until software has written it once since reset. The memory mastering that moves the data is not part of this block.

Top module: `xfer_count24`

## Requirements
- R1: After reset the working count reads 0, and tc, busy, dma_mode and done are all 0.
- R2: A host write to count address 0 (low byte), 1 (middle byte) or 2 (high byte) updates only the holding byte. The readback of the working count does not change, and tc clears on the following cycle. A write to address 3 has no effect.
- R3: A command (cmd_stb) with cmd_dma=1 copies the holding bytes into the working count and sets dma_mode. A command with cmd_dma=0 clears dma_mode and leaves the count unchanged.
- R4: A read of address 2 returns the parameter ID_BYTE until address 2 has been written after reset. From then on it returns bits 23:16 of the working count. Address 3 always reads 0.
- R5: A command with cmd_dma=1 and cmd_xfer=1 starts a run. Its length is min(holding count, or 65536 if that count is 0; phase_left). The working count takes that length, tc clears and busy sets.
- R6: While busy, each byte_stb cycle without a count write or a command lowers the working count by exactly 1.
- R7: The strobe that takes the count from 1 to 0 clears busy and sets tc. It also raises done for exactly one cycle.
- R8: When a count write and byte_stb fall in the same cycle, the write wins. The strobe is dropped, the count holds and tc stays clear.
- R9: A run whose length works out to 0 sets tc and pulses done on the cycle after the command, without becoming busy.
- R10: A command with cmd_xfer=1 but cmd_dma=0 starts no run and does not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hard reset |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 2 | Write address: 0 low, 1 middle, 2 high, 3 unused |
| reg_wdata | input | 8 | Write data byte |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 8 | Combinational readback of the working count |
| cmd_stb | input | 1 | Command strobe |
| cmd_dma | input | 1 | DMA flag of the command |
| cmd_xfer | input | 1 | Command requests a transfer run |
| phase_left | input | 24 | Bytes left in the current bus phase, sampled at start |
| byte_stb | input | 1 | One byte moved this cycle |
| dma_mode | output | 1 | Last command carried the DMA flag |
| busy | output | 1 | Run in progress |
| tc | output | 1 | Terminal count reached |
| done | output | 1 | One-cycle pulse at transfer completion |

## Verification
Every registered result appears one clock edge after the stimulus. The count, tc, busy, dma_mode and the done pulse all change on the edge that samples the write, command or strobe. rd_data follows rd_addr combinationally from that registered state. The bench drives inputs on the falling edge and advances its model for the coming rising edge. It compares every output and all three read addresses at the next falling edge, so each result is checked in the cycle it is due. The single-cycle width of done is checked by this every-cycle comparison.

// File: rtl/xfer_count24.sv
module xfer_count24 #(
  parameter logic [7:0] ID_BYTE = 8'hA5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  input  logic [1:0]  rd_addr,
  output logic [7:0]  rd_data,
  input  logic        cmd_stb,
  input  logic        cmd_dma,
  input  logic        cmd_xfer,
  input  logic [23:0] phase_left,
  input  logic        byte_stb,
  output logic        dma_mode,
  output logic        busy,
  output logic        tc,
  output logic        done
);
  localparam logic [23:0] WRAP_LEN = 24'h010000;

  logic [7:0]  hold_lo, hold_mid, hold_hi;
  logic [23:0] cnt_q;
  logic        hi_seen_q, tc_q, dma_q, busy_q, done_q;

  wire        cnt_wr   = reg_wr && (reg_addr != 2'd3);
  wire        start    = cmd_stb && cmd_dma && cmd_xfer;
  wire [23:0] hold     = {hold_hi, hold_mid, hold_lo};
  wire [23:0] want     = (hold == 24'd0) ? WRAP_LEN : hold;
  wire [23:0] run_len  = (phase_left < want) ? phase_left : want;
  wire        step     = busy_q && byte_stb && !cnt_wr && !cmd_stb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_lo   <= '0;
      hold_mid  <= '0;
      hold_hi   <= '0;
      cnt_q     <= '0;
      hi_seen_q <= 1'b0;
      tc_q      <= 1'b0;
      dma_q     <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cnt_wr) begin
        tc_q <= 1'b0;
        case (reg_addr)
          2'd0:    hold_lo  <= reg_wdata;
          2'd1:    hold_mid <= reg_wdata;
          default: begin
            hold_hi   <= reg_wdata;
            hi_seen_q <= 1'b1;
          end
        endcase
      end
      if (cmd_stb) begin
        dma_q <= cmd_dma;
        if (cmd_dma) cnt_q <= hold;
        if (start) begin
          cnt_q  <= run_len;
          tc_q   <= (run_len == 24'd0);
          busy_q <= (run_len != 24'd0);
          done_q <= (run_len == 24'd0);
        end
      end else if (step) begin
        cnt_q <= cnt_q - 24'd1;
        if (cnt_q == 24'd1) begin
          busy_q <= 1'b0;
          tc_q   <= 1'b1;
          done_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = cnt_q[7:0];
      2'd1:    rd_data = cnt_q[15:8];
      2'd2:    rd_data = hi_seen_q ? cnt_q[23:16] : ID_BYTE;
      default: rd_data = 8'h00;
    endcase
  end

  assign dma_mode = dma_q;
  assign busy     = busy_q;
  assign tc       = tc_q;
  assign done     = done_q;

  a_r6_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && byte_stb && !cnt_wr && !cmd_stb) |=> (cnt_q == $past(cnt_q) - 24'd1));

  a_r7_done_state: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tc && !busy && cnt_q == 24'd0));

  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && !cmd_stb) |=> (!tc && cnt_q == $past(cnt_q)));

  a_r5_start_clears_or_ends: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy != done));

  a_r4_id_until_written: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_seen_q && rd_addr == 2'd2) |-> (rd_data == ID_BYTE));

  a_r3_dma_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> (dma_mode == $past(cmd_dma)));
endmodule

// File: tb/xfer_count24_bench.sv
module xfer_count24_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] ID = 8'hA5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, cmd_stb = 0, cmd_dma = 0, cmd_xfer = 0, byte_stb = 0;
  logic [1:0] reg_addr = 0, rd_addr = 0;
  logic [7:0] reg_wdata = 0, rd_data;
  logic [23:0] phase_left = 0;
  logic dma_mode, busy, tc, done;

  int tests = 0, fails = 0;
  int m_sh[3];
  int m_live, m_hiw, m_tc, m_busy, m_dma, m_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_count24 #(.ID_BYTE(ID)) u_xfer_count24 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .cmd_stb(cmd_stb), .cmd_dma(cmd_dma), .cmd_xfer(cmd_xfer),
    .phase_left(phase_left), .byte_stb(byte_stb), .dma_mode(dma_mode),
    .busy(busy), .tc(tc), .done(done));

  task automatic chk(string tag, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "done", done, m_done);
    chk(tag, "tc", tc, m_tc);
    chk(tag, "busy", busy, m_busy);
    chk(tag, "dma_mode", dma_mode, m_dma);
    for (int a = 0; a < 4; a++) begin
      int exp;
      rd_addr = a[1:0];
      #1;
      case (a)
        0: exp = m_live & 'hff;
        1: exp = (m_live >> 8) & 'hff;
        2: exp = m_hiw ? ((m_live >> 16) & 'hff) : ID;
        default: exp = 0;
      endcase
      chk(tag, $sformatf("rd[%0d]", a), rd_data, exp);
    end
  endtask

  task automatic step(string tag, bit wr, int a, int d, bit cs, bit cd, bit cx,
                      int ph, bit bs);
    int old_sh, len;
    bit cw;
    reg_wr = wr; reg_addr = a[1:0]; reg_wdata = d[7:0];
    cmd_stb = cs; cmd_dma = cd; cmd_xfer = cx; phase_left = ph[23:0]; byte_stb = bs;
    old_sh = m_sh[0] | (m_sh[1] << 8) | (m_sh[2] << 16);
    cw = wr && (a != 3);
    m_done = 0;
    if (cw) begin
      m_sh[a] = d & 'hff;
      if (a == 2) m_hiw = 1;
      m_tc = 0;
    end
    if (cs) begin
      m_dma = cd;
      if (cd) m_live = old_sh;
      if (cd && cx) begin
        len = (old_sh == 0) ? 65536 : old_sh;
        if (ph < len) len = ph;
        m_live = len;
        m_tc = (len == 0);
        m_busy = (len != 0);
        m_done = (len == 0);
      end
    end else if (m_busy && bs && !cw) begin
      m_live--;
      if (m_live == 0) begin m_busy = 0; m_tc = 1; m_done = 1; end
    end
    @(posedge clk);
    @(negedge clk);
    reg_wr = 0; cmd_stb = 0; byte_stb = 0;
    compare(tag);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    m_sh = '{0, 0, 0};
    m_live = 0; m_hiw = 0; m_tc = 0; m_busy = 0; m_dma = 0; m_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare("R1");
    idle("R1");
    // R2: holding writes do not touch the working count; address 3 ignored
    step("R2", 1, 0, 'h05, 0, 0, 0, 0, 0);
    step("R2", 1, 1, 'h00, 0, 0, 0, 0, 0);
    step("R2", 1, 3, 'h77, 0, 0, 0, 0, 0);
    // R3: DMA command copies holding bytes; R4 high byte still ID
    step("R3", 0, 0, 0, 1, 1, 0, 0, 0);
    step("R4", 1, 2, 'h00, 0, 0, 0, 0, 0);
    step("R3", 0, 0, 0, 1, 0, 0, 0, 0);
    // R10: transfer request without DMA flag
    step("R10", 0, 0, 0, 1, 0, 1, 50, 0);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 1);
    // R5: phase shorter than count, then R6/R7 count down
    step("R5", 0, 0, 0, 1, 1, 1, 3, 0);
    step("R6", 0, 0, 0, 0, 0, 0, 0, 1);
    idle("R6");
    step("R6", 0, 0, 0, 0, 0, 0, 0, 1);
    step("R7", 0, 0, 0, 0, 0, 0, 0, 1);
    idle("R7");
    step("R7", 0, 0, 0, 0, 0, 0, 0, 1);
    step("R2", 1, 0, 'h05, 0, 0, 0, 0, 0);
    // R8: write beats strobe
    step("R5", 0, 0, 0, 1, 1, 1, 100, 0);
    step("R8", 1, 1, 'h00, 0, 0, 0, 0, 1);
    step("R6", 0, 0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 4; i++) step("R7", 0, 0, 0, 0, 0, 0, 0, 1);
    // R8: write in the cycle that would finish the run
    step("R5", 1, 2, 'h00, 0, 0, 0, 0, 0);
    step("R5", 1, 0, 'h01, 0, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 1, 1, 1, 9, 0);
    step("R8", 1, 1, 'h00, 0, 0, 0, 0, 1);
    step("R7", 0, 0, 0, 0, 0, 0, 0, 1);
    // R5: zero count means 65536, full run to terminal count
    step("R5", 1, 0, 'h00, 0, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 1, 1, 1, 'h20000, 0);
    for (int i = 0; i < 65536; i++) step(i == 65535 ? "R7" : "R6", 0, 0, 0, 0, 0, 0, 0, 1);
    idle("R7");
    // R9: zero phase gives an immediate done
    step("R9", 1, 0, 'h04, 0, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 1, 1, 1, 0, 0);
    idle("R9");
    // R1: hard reset restores ID readback
    rst_n = 0;
    m_sh = '{0, 0, 0};
    m_live = 0; m_hiw = 0; m_tc = 0; m_busy = 0; m_dma = 0; m_done = 0;
    @(negedge clk);
    rst_n = 1;
    compare("R1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule